// File: doc/BRIEF.md
# Multimedia Register File with Opcode Decode and Fault Gate

This block is the front end of a small 64-bit packed-integer unit. It holds eight 64-bit vector registers with one tag bit each. It takes the second byte of a two-byte escape opcode and decodes it. It then runs a register move, a pack with saturation, a packed add or the state-clear operation. Accepted instructions arrive one per cycle with `valid_i`. Operand A is always a vector register. Operand B is either a vector register or the external 64-bit operand `opnd_i`, which stands for a memory or general-register value that has already been fetched.

Before anything is committed, three control inputs are checked with a fixed priority. These are the emulation flag, the task-switched flag and a pending floating-point exception. A faulting instruction reports an exception vector and leaves the state unchanged. A good instruction writes one register, or drives the store port, or clears the tags. All results appear at the outputs one clock after the instruction is accepted.

Top module: `simd_front`

## Requirements
- R1: Only these second-byte opcodes are recognised: 77h, 6Eh, 7Eh, 6Fh, 7Fh, 6Bh, 63h, 67h, FCh, FEh and ECh. For any other byte, `done_o` stays 0 and no register, tag or store output changes.
- R2: Reset clears all registers and tags and sets every output to 0. A recognised instruction accepted in cycle t raises `done_o` for exactly cycle t+1. Its fault, store and state updates become visible in that same cycle.
- R3: Faults are checked in this priority order:
  - vector 6 if `emul_i` is 1 or if the encoding is illegal (see R8);
  - otherwise vector 7 if `task_sw_i` is 1;
  - otherwise vector 16 if `fp_pend_i` is 1.
  At most one vector is reported. `fault_vec_o` is 0 whenever `fault_o` is 0.
- R4: A faulting instruction writes no register, leaves the tags unchanged and does not raise `st_valid_o`.
- R5: Opcode 6Eh writes `opnd_i[31:0]` into bits 31..0 of register A and writes zero into bits 63..32.
- R6: Opcode 7Eh raises `st_valid_o` with `st_data_o` = bits 31..0 of register A, zero-extended to 64 bits.
- R7: Opcode 6Fh copies operand B into register A. Opcode 7Fh has two forms:
  - with `b_mem_i`=1 it stores register A on `st_data_o`;
  - with `b_mem_i`=0 it copies register A into register B.
- R8: Operand A must be a register. With `a_mem_i`=1, every recognised opcode except 77h raises vector 6. This also rejects any memory-to-memory move.
- R9: 6Bh packs signed 32-bit values into signed 16-bit values, saturating to 7FFFh and 8000h. 63h packs signed 16-bit values into signed 8-bit values, saturating to 7Fh and 80h. In both, the lower half of the result holds the packed lanes of register A, low lane first. The upper half holds the packed lanes of operand B.
- R10: 67h packs signed 16-bit values into unsigned 8-bit values, using the same lane layout as R9. Negative values become 00h and values above 255 become FFh.
- R11: FCh adds per byte and FEh adds per 32-bit lane, each modulo its lane width with no carry between lanes. The result is written to register A.
- R12: ECh adds signed bytes and clamps each sum to the range -128..127. The result is written to register A.
- R13: Tags reset to all 0 (empty). A committed 77h sets all tags to 0 and leaves the register contents unchanged. Every other committed instruction sets all tags to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 8 | Second opcode byte |
| reg_a_i | input | 3 | Register index of operand A (destination for in-direction ops) |
| reg_b_i | input | 3 | Register index of operand B |
| a_mem_i | input | 1 | Operand A encoded as memory (illegal) |
| b_mem_i | input | 1 | Operand B is the external operand or store target |
| opnd_i | input | 64 | External operand value |
| emul_i | input | 1 | Emulation flag |
| task_sw_i | input | 1 | Task-switched flag |
| fp_pend_i | input | 1 | Floating-point exception pending |
| done_o | output | 1 | A recognised instruction completed |
| fault_o | output | 1 | That instruction faulted |
| fault_vec_o | output | 5 | Exception vector (6, 7, 16) or 0 |
| st_valid_o | output | 1 | Store or general-register result valid |
| st_data_o | output | 64 | Store data, 0 when not storing |
| tag_o | output | 8 | Per-register tag bits |

## Verification
A corrupted register or a wrong lane of a pack or add does not show at the ports right away. It shows only when the affected register is later moved out through 7Eh or 7Fh. For this reason, every write is followed straight away by a 64-bit store of the same register, which catches the error within two cycles. A wrong fault priority or a missing fault gate shows in the cycle after the instruction, as a wrong vector or an unexpected store. A write that slips through during a fault shows at the next store of that register. Tag errors appear on `tag_o` in the cycle after the instruction that should have changed them.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLR,
    OP_MVD_IN,
    OP_MVD_OUT,
    OP_MVQ_IN,
    OP_MVQ_OUT,
    OP_PK_DW,
    OP_PK_WB,
    OP_PK_UWB,
    OP_ADD_B,
    OP_ADD_D,
    OP_ADDS_B
  } op_e;

  localparam logic [7:0] OPC_CLR     = 8'h77;
  localparam logic [7:0] OPC_MVD_IN  = 8'h6E;
  localparam logic [7:0] OPC_MVD_OUT = 8'h7E;
  localparam logic [7:0] OPC_MVQ_IN  = 8'h6F;
  localparam logic [7:0] OPC_MVQ_OUT = 8'h7F;
  localparam logic [7:0] OPC_PK_DW   = 8'h6B;
  localparam logic [7:0] OPC_PK_WB   = 8'h63;
  localparam logic [7:0] OPC_PK_UWB  = 8'h67;
  localparam logic [7:0] OPC_ADD_B   = 8'hFC;
  localparam logic [7:0] OPC_ADD_D   = 8'hFE;
  localparam logic [7:0] OPC_ADDS_B  = 8'hEC;

  localparam int unsigned VW = 5;
  localparam logic [VW-1:0] VEC_NONE = 5'd0;
  localparam logic [VW-1:0] VEC_UD   = 5'd6;
  localparam logic [VW-1:0] VEC_NM   = 5'd7;
  localparam logic [VW-1:0] VEC_MF   = 5'd16;

  function automatic logic is_lane_op(op_e op);
    return op inside {OP_PK_DW, OP_PK_WB, OP_PK_UWB, OP_ADD_B, OP_ADD_D, OP_ADDS_B};
  endfunction

  // signed 32 -> signed 16, clamp
  function automatic logic [15:0] sat_s32_s16(logic [31:0] x);
    if (&x[31:15] || ~|x[31:15]) return x[15:0];
    return x[31] ? 16'h8000 : 16'h7FFF;
  endfunction

  // signed 16 -> signed 8, clamp
  function automatic logic [7:0] sat_s16_s8(logic [15:0] x);
    if (&x[15:7] || ~|x[15:7]) return x[7:0];
    return x[15] ? 8'h80 : 8'h7F;
  endfunction

  // signed 16 -> unsigned 8, clamp
  function automatic logic [7:0] sat_s16_u8(logic [15:0] x);
    if (x[15]) return 8'h00;
    if (|x[14:8]) return 8'hFF;
    return x[7:0];
  endfunction

  function automatic logic [7:0] add_sat_s8(logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    s = {a[7], a} + {b[7], b};
    if (s[8] != s[7]) return s[8] ? 8'h80 : 8'h7F;
    return s[7:0];
  endfunction

endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
(
  input  logic [7:0] opcode_i,
  output op_e        op_o
);

  always_comb begin
    case (opcode_i)
      OPC_CLR:     op_o = OP_CLR;
      OPC_MVD_IN:  op_o = OP_MVD_IN;
      OPC_MVD_OUT: op_o = OP_MVD_OUT;
      OPC_MVQ_IN:  op_o = OP_MVQ_IN;
      OPC_MVQ_OUT: op_o = OP_MVQ_OUT;
      OPC_PK_DW:   op_o = OP_PK_DW;
      OPC_PK_WB:   op_o = OP_PK_WB;
      OPC_PK_UWB:  op_o = OP_PK_UWB;
      OPC_ADD_B:   op_o = OP_ADD_B;
      OPC_ADD_D:   op_o = OP_ADD_D;
      OPC_ADDS_B:  op_o = OP_ADDS_B;
      default:     op_o = OP_NONE;
    endcase
  end

endmodule

// File: rtl/simd_fault_gate.sv
module simd_fault_gate
  import simd_pkg::*;
(
  input  logic          valid_i,
  input  op_e           op_i,
  input  logic          a_mem_i,
  input  logic          emul_i,
  input  logic          task_sw_i,
  input  logic          fp_pend_i,
  output logic          fault_o,
  output logic [VW-1:0] vec_o
);

  logic live;
  logic bad_enc;

  assign live    = valid_i && (op_i != OP_NONE);
  assign bad_enc = a_mem_i && (op_i != OP_CLR);

  always_comb begin
    vec_o = VEC_NONE;
    if (live) begin
      if (emul_i || bad_enc) vec_o = VEC_UD;
      else if (task_sw_i)    vec_o = VEC_NM;
      else if (fp_pend_i)    vec_o = VEC_MF;
    end
  end

  assign fault_o = (vec_o != VEC_NONE);

  // R3: emulation dominates the other two sources
  always_comb begin
    if (live && emul_i) a_r3_ud_wins: assert (vec_o == VEC_UD);
    if (!live)          a_r1_no_fault_idle: assert (!fault_o);
  end

endmodule

// File: rtl/simd_lanes.sv
module simd_lanes
  import simd_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  localparam int unsigned NB = W / 8;
  localparam int unsigned ND = W / 32;
  localparam int unsigned NH = W / 16;

  logic [2*W-1:0] cat;
  logic [W-1:0]   add_b, adds_b, add_d, pk_dw, pk_wb, pk_uwb;

  // A supplies the low result half, B the high half
  assign cat = {b_i, a_i};

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign add_b[8*g +: 8]  = a_i[8*g +: 8] + b_i[8*g +: 8];
    assign adds_b[8*g +: 8] = add_sat_s8(a_i[8*g +: 8], b_i[8*g +: 8]);
    assign pk_wb[8*g +: 8]  = sat_s16_s8(cat[16*g +: 16]);
    assign pk_uwb[8*g +: 8] = sat_s16_u8(cat[16*g +: 16]);
  end

  for (genvar g = 0; g < ND; g++) begin : g_dword
    assign add_d[32*g +: 32] = a_i[32*g +: 32] + b_i[32*g +: 32];
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    assign pk_dw[16*g +: 16] = sat_s32_s16(cat[32*g +: 32]);
  end

  always_comb begin
    case (op_i)
      OP_PK_DW:  res_o = pk_dw;
      OP_PK_WB:  res_o = pk_wb;
      OP_PK_UWB: res_o = pk_uwb;
      OP_ADD_B:  res_o = add_b;
      OP_ADD_D:  res_o = add_d;
      OP_ADDS_B: res_o = adds_b;
      default:   res_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_front.sv
module simd_front
  import simd_pkg::*;
#(
  parameter int unsigned NREG = 8,
  parameter int unsigned W    = 64,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned HW  = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [7:0]    opcode_i,
  input  logic [IW-1:0] reg_a_i,
  input  logic [IW-1:0] reg_b_i,
  input  logic          a_mem_i,
  input  logic          b_mem_i,
  input  logic [W-1:0]  opnd_i,
  input  logic          emul_i,
  input  logic          task_sw_i,
  input  logic          fp_pend_i,
  output logic          done_o,
  output logic          fault_o,
  output logic [VW-1:0] fault_vec_o,
  output logic          st_valid_o,
  output logic [W-1:0]  st_data_o,
  output logic [NREG-1:0] tag_o
);

  op_e               op;
  logic              live, flt, commit;
  logic [VW-1:0]     vec;
  logic [NREG-1:0][W-1:0] rf_q;
  logic [NREG-1:0]   tag_q;
  logic [W-1:0]      a_val, b_val, lane_res;
  logic              wr_en, st_en;
  logic [IW-1:0]     wr_idx;
  logic [W-1:0]      wr_data, st_dat;
  logic              done_q, fault_q, st_v_q;
  logic [VW-1:0]     vec_q;
  logic [W-1:0]      st_d_q;

  simd_decode u_dec (
    .opcode_i (opcode_i),
    .op_o     (op)
  );

  simd_fault_gate u_gate (
    .valid_i   (valid_i),
    .op_i      (op),
    .a_mem_i   (a_mem_i),
    .emul_i    (emul_i),
    .task_sw_i (task_sw_i),
    .fp_pend_i (fp_pend_i),
    .fault_o   (flt),
    .vec_o     (vec)
  );

  assign live   = valid_i && (op != OP_NONE);
  assign commit = live && !flt;
  assign a_val  = rf_q[reg_a_i];
  assign b_val  = b_mem_i ? opnd_i : rf_q[reg_b_i];

  simd_lanes #(.W(W)) u_lanes (
    .op_i  (op),
    .a_i   (a_val),
    .b_i   (b_val),
    .res_o (lane_res)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = reg_a_i;
    wr_data = lane_res;
    st_en   = 1'b0;
    st_dat  = '0;
    case (op)
      OP_MVD_IN: begin
        wr_en   = 1'b1;
        wr_data = {{HW{1'b0}}, opnd_i[HW-1:0]};
      end
      OP_MVD_OUT: begin
        st_en  = 1'b1;
        st_dat = {{HW{1'b0}}, a_val[HW-1:0]};
      end
      OP_MVQ_IN: begin
        wr_en   = 1'b1;
        wr_data = b_val;
      end
      OP_MVQ_OUT: begin
        if (b_mem_i) begin
          st_en  = 1'b1;
          st_dat = a_val;
        end else begin
          wr_en   = 1'b1;
          wr_idx  = reg_b_i;
          wr_data = a_val;
        end
      end
      default: wr_en = is_lane_op(op);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_q    <= '0;
      tag_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      vec_q   <= VEC_NONE;
      st_v_q  <= 1'b0;
      st_d_q  <= '0;
    end else begin
      done_q  <= live;
      fault_q <= flt;
      vec_q   <= vec;
      st_v_q  <= commit && st_en;
      st_d_q  <= (commit && st_en) ? st_dat : '0;
      if (commit) tag_q <= (op == OP_CLR) ? '0 : '1;
      if (commit && wr_en) rf_q[wr_idx] <= wr_data;
    end
  end

  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign fault_vec_o = vec_q;
  assign st_valid_o  = st_v_q;
  assign st_data_o   = st_d_q;
  assign tag_o       = tag_q;

  a_r4_fault_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($stable(rf_q) && $stable(tag_q) && !st_valid_o));

  a_r1_idle_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |=> ($stable(rf_q) && $stable(tag_q) && !done_o));

  a_r2_done_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |=> done_o);

  a_r3_vec_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_vec_o == VEC_UD || fault_vec_o == VEC_NM || fault_vec_o == VEC_MF));

  a_r3_vec_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (fault_vec_o == VEC_NONE));

  a_r13_clear_tags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && op == OP_CLR && !flt) |=> (tag_o == '0 && $stable(rf_q)));

  a_r6_movd_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && op == OP_MVD_OUT && !flt) |=> (st_valid_o && st_data_o[W-1:HW] == '0));

  a_r4_store_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fault_o, st_valid_o}));

endmodule

// File: tb/simd_front_test.sv
module simd_front_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [2:0]  reg_a_i = '0, reg_b_i = '0;
  logic        a_mem_i = 1'b0, b_mem_i = 1'b0;
  logic [63:0] opnd_i = '0;
  logic        emul_i = 1'b0, task_sw_i = 1'b0, fp_pend_i = 1'b0;
  logic        done_o, fault_o, st_valid_o;
  logic [4:0]  fault_vec_o;
  logic [63:0] st_data_o;
  logic [7:0]  tag_o;

  int tests = 0;
  int fails = 0;
  logic [63:0] m_rf [8];
  logic [7:0]  m_tag;

  always #4 clk_i = ~clk_i;

  simd_front uut (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .reg_a_i, .reg_b_i, .a_mem_i, .b_mem_i,
    .opnd_i, .emul_i, .task_sw_i, .fp_pend_i, .done_o, .fault_o, .fault_vec_o,
    .st_valid_o, .st_data_o, .tag_o
  );

  task automatic chk(string rq, string what, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", rq, what, got, exp);
    end
  endtask

  function automatic logic [15:0] e_ss16(logic [31:0] v);
    int x = int'($signed(v));
    if (x > 32767) return 16'h7FFF;
    if (x < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic [7:0] e_ss8(logic [15:0] v);
    int x = int'($signed(v));
    if (x > 127) return 8'h7F;
    if (x < -128) return 8'h80;
    return v[7:0];
  endfunction

  function automatic logic [7:0] e_us8(logic [15:0] v);
    int x = int'($signed(v));
    if (x < 0) return 8'h00;
    if (x > 255) return 8'hFF;
    return v[7:0];
  endfunction

  function automatic logic [63:0] e_calc(logic [7:0] opc, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    case (opc)
      8'h6B: for (int i = 0; i < 4; i++)
               r[16*i +: 16] = e_ss16(i < 2 ? a[32*i +: 32] : b[32*(i-2) +: 32]);
      8'h63: for (int i = 0; i < 8; i++)
               r[8*i +: 8] = e_ss8(i < 4 ? a[16*i +: 16] : b[16*(i-4) +: 16]);
      8'h67: for (int i = 0; i < 8; i++)
               r[8*i +: 8] = e_us8(i < 4 ? a[16*i +: 16] : b[16*(i-4) +: 16]);
      8'hFC: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*i +: 8] + b[8*i +: 8];
      8'hFE: for (int i = 0; i < 2; i++) r[32*i +: 32] = a[32*i +: 32] + b[32*i +: 32];
      8'hEC: for (int i = 0; i < 8; i++) begin
               int s = int'($signed(a[8*i +: 8])) + int'($signed(b[8*i +: 8]));
               if (s > 127) s = 127;
               if (s < -128) s = -128;
               r[8*i +: 8] = s[7:0];
             end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string rq_of(logic [7:0] opc);
    case (opc)
      8'h77: return "R13";
      8'h6E: return "R5";
      8'h7E: return "R6";
      8'h6F, 8'h7F: return "R7";
      8'h6B, 8'h63: return "R9";
      8'h67: return "R10";
      8'hFC, 8'hFE: return "R11";
      8'hEC: return "R12";
      default: return "R1";
    endcase
  endfunction

  // drive at a falling edge, check at the next one
  task automatic run(input logic [7:0] opc, input logic [2:0] a, input logic [2:0] b,
                     input logic am, input logic bm, input logic [63:0] opnd,
                     input logic e, input logic t, input logic f, input string rq,
                     output logic did_wr, output logic [2:0] widx);
    logic known, commit, est;
    logic [4:0] ev;
    logic [63:0] av, bv, ed, wdat;
    logic [7:0] etag;
    valid_i = 1'b1; opcode_i = opc; reg_a_i = a; reg_b_i = b; a_mem_i = am; b_mem_i = bm;
    opnd_i = opnd; emul_i = e; task_sw_i = t; fp_pend_i = f;
    @(negedge clk_i);
    known = opc inside {8'h77, 8'h6E, 8'h7E, 8'h6F, 8'h7F, 8'h6B, 8'h63, 8'h67, 8'hFC, 8'hFE, 8'hEC};
    ev = !known ? 5'd0 : (e || (am && opc != 8'h77)) ? 5'd6 : t ? 5'd7 : f ? 5'd16 : 5'd0;
    commit = known && ev == 0;
    av = m_rf[a];
    bv = bm ? opnd : m_rf[b];
    est = 1'b0; ed = '0; did_wr = 1'b0; widx = a; wdat = '0;
    if (commit) begin
      case (opc)
        8'h6E: begin did_wr = 1'b1; wdat = {32'h0, opnd[31:0]}; end
        8'h7E: begin est = 1'b1; ed = {32'h0, av[31:0]}; end
        8'h6F: begin did_wr = 1'b1; wdat = bv; end
        8'h7F: if (bm) begin est = 1'b1; ed = av; end
               else begin did_wr = 1'b1; widx = b; wdat = av; end
        8'h77: ;
        default: begin did_wr = 1'b1; wdat = e_calc(opc, av, bv); end
      endcase
    end
    etag = commit ? ((opc == 8'h77) ? 8'h00 : 8'hFF) : m_tag;
    chk(known ? "R2" : "R1", "done", {63'b0, done_o}, {63'b0, known});
    chk(ev != 0 ? "R3" : rq, "fault", {63'b0, fault_o}, {63'b0, ev != 0});
    chk("R3", "vector", {59'b0, fault_vec_o}, {59'b0, ev});
    chk(ev != 0 ? "R4" : rq, "st_valid", {63'b0, st_valid_o}, {63'b0, est});
    chk(rq, "st_data", st_data_o, ed);
    chk(ev != 0 ? "R4" : "R13", "tags", {56'b0, tag_o}, {56'b0, etag});
    m_tag = etag;
    if (did_wr) m_rf[widx] = wdat;
  endtask

  task automatic dump(input logic [2:0] r, input string rq);
    logic w; logic [2:0] x;
    run(8'h7F, r, 3'd0, 1'b0, 1'b1, 64'h0, 1'b0, 1'b0, 1'b0, rq, w, x);
  endtask

  task automatic load(input logic [2:0] r, input logic [63:0] v);
    logic w; logic [2:0] x;
    run(8'h6F, r, 3'd0, 1'b0, 1'b1, v, 1'b0, 1'b0, 1'b0, "R7", w, x);
  endtask

  task automatic op2(input logic [7:0] opc, input logic [2:0] a, input logic [63:0] bval,
                     input logic e, input logic t, input logic f, input string rq);
    logic w; logic [2:0] x;
    run(opc, a, 3'd0, 1'b0, 1'b1, bval, e, t, f, rq, w, x);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic w; logic [2:0] x;
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    m_tag = '0;
    repeat (3) @(negedge clk_i);
    chk("R2", "reset done", {63'b0, done_o}, 64'd0);
    chk("R2", "reset fault", {59'b0, fault_o, fault_vec_o}, 64'd0);
    chk("R13", "reset tags", {56'b0, tag_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    dump(3'd5, "R2");

    // R5 / R6 upper half handling
    load(3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    op2(8'h6E, 3'd1, 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0, 1'b0, "R5");
    dump(3'd1, "R5");
    load(3'd2, 64'hCAFE_F00D_8765_4321);
    run(8'h7E, 3'd2, 3'd0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, "R6", w, x);
    // R7 register-to-register copy
    run(8'h7F, 3'd2, 3'd6, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, "R7", w, x);
    dump(3'd6, "R7");

    // R9 / R10 / R11 / R12 directed
    load(3'd0, 64'hFFFF_8002_0000_01FC);
    op2(8'h6B, 3'd0, 64'h8000_0002_0000_8000, 1'b0, 1'b0, 1'b0, "R9");
    dump(3'd0, "R9");
    chk("R9", "dw pack value", m_rf[0], 64'h8000_7FFF_8002_01FC);
    load(3'd3, 64'hFF02_0085_007E_81CF);
    op2(8'h63, 3'd3, 64'h007E_7F00_EF9D_FF88, 1'b0, 1'b0, 1'b0, "R9");
    dump(3'd3, "R9");
    chk("R9", "wb pack value", m_rf[3], 64'h7E7F_8088_807F_7E80);
    load(3'd4, 64'h0002_023A_007E_FFF8);
    op2(8'h67, 3'd4, 64'h0112_008B_0300_FF88, 1'b0, 1'b0, 1'b0, "R10");
    dump(3'd4, "R10");
    chk("R10", "uwb pack value", m_rf[4], 64'hFF8B_FF00_02FF_7E00);
    load(3'd5, 64'h0123_4567_FFF0_5C43);
    op2(8'hFE, 3'd5, 64'h8000_0000_000F_A3BE, 1'b0, 1'b0, 1'b0, "R11");
    dump(3'd5, "R11");
    chk("R11", "dword add value", m_rf[5], 64'h8123_4567_0000_0001);
    load(3'd6, 64'h53FC_0102_0304_0506);
    op2(8'hFC, 3'd6, 64'hEC14_0101_0101_0101, 1'b0, 1'b0, 1'b0, "R11");
    dump(3'd6, "R11");
    load(3'd7, 64'h7F80_649C_10F0_0001);
    op2(8'hEC, 3'd7, 64'h01FF_649C_10F0_00FF, 1'b0, 1'b0, 1'b0, "R12");
    dump(3'd7, "R12");
    chk("R12", "sat add value", m_rf[7], 64'h7F80_7F80_20E0_0000);

    // R3 priority, R4 no effect
    op2(8'hFC, 3'd7, 64'h1111_1111_1111_1111, 1'b1, 1'b1, 1'b1, "R3");
    op2(8'hFC, 3'd7, 64'h1111_1111_1111_1111, 1'b0, 1'b1, 1'b1, "R3");
    op2(8'hFC, 3'd7, 64'h1111_1111_1111_1111, 1'b0, 1'b0, 1'b1, "R3");
    run(8'h7E, 3'd7, 3'd0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, "R4", w, x);
    dump(3'd7, "R4");
    // R8 operand A in memory, incl. memory-to-memory
    run(8'h6F, 3'd2, 3'd0, 1'b1, 1'b1, 64'h5555, 1'b0, 1'b0, 1'b0, "R8", w, x);
    run(8'h7F, 3'd2, 3'd0, 1'b1, 1'b1, 64'h5555, 1'b0, 1'b0, 1'b0, "R8", w, x);
    run(8'h77, 3'd0, 3'd0, 1'b1, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, "R8", w, x);
    dump(3'd2, "R8");
    // R13 clear keeps data, faulting clear keeps tags
    run(8'h77, 3'd0, 3'd0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R13", w, x);
    run(8'h77, 3'd0, 3'd0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, "R13", w, x);
    dump(3'd3, "R13");
    // R1 unknown opcodes
    run(8'h90, 3'd3, 3'd1, 1'b0, 1'b0, 64'hFFFF, 1'b0, 1'b0, 1'b0, "R1", w, x);
    run(8'h6C, 3'd3, 3'd1, 1'b0, 1'b1, 64'hFFFF, 1'b1, 1'b0, 1'b0, "R1", w, x);
    dump(3'd3, "R1");

    // constrained random
    void'($urandom(32'd4242));
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] opc;
      logic [63:0] v;
      logic [2:0] ra, rb;
      int k = $urandom_range(0, 11);
      case (k)
        0: opc = 8'h77;  1: opc = 8'h6E;  2: opc = 8'h7E;  3: opc = 8'h6F;
        4: opc = 8'h7F;  5: opc = 8'h6B;  6: opc = 8'h63;  7: opc = 8'h67;
        8: opc = 8'hFC;  9: opc = 8'hFE;  10: opc = 8'hEC;
        default: opc = 8'($urandom);
      endcase
      v = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) v = v & 64'h01FF_81FF_0080_FF7F;
      ra = 3'($urandom); rb = 3'($urandom);
      run(opc, ra, rb, $urandom_range(0, 15) == 0, 1'($urandom), v,
          $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
          $urandom_range(0, 15) == 0, rq_of(opc), w, x);
      if (w) dump(x, rq_of(opc));
    end

    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R1", "idle done", {63'b0, done_o}, 64'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule